// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block decides, cycle by cycle, whether a new operation may be launched into a static single-function pipeline whose stages are reused through feedback paths. The usage pattern of the pipeline is supplied as a reservation table parameter: one row per stage, one column per time slot, with a set bit marking a slot in which that stage is busy. At elaboration the block finds every latency that would make two operations need the same stage in the same slot, and it packs these latencies into a collision vector.

A shift register holds the current occupancy state. Each clock it moves one place toward the least significant end, and a zero enters at the top. The bit leaving at the bottom says whether a start in the present cycle would collide. When a start is granted, the collision vector is merged into the shifted value, so the register reflects both the older and the newly launched operations. A request that arrives while starts are blocked is remembered and granted in the first cycle that allows it. The requester does not have to keep it asserted.

Top module: `pipe_init_ctrl`

## Requirements
- R1: Bit k-1 of the collision vector is 1 exactly when latency k is forbidden, meaning some table row has marked slots k apart. Row s of RES_TABLE occupies bits [s*SLOTS +: SLOTS], and slot t is bit t within its row. The default 3x7 table (rows 1000001, 0001010, 1000100, slot 0 rightmost) gives 6'b101010.
- R2: After reset the state register is all zeros and no grant is issued.
- R3: In any cycle, grant_o is 1 only when bit 0 of the state register is 0. A new or held request is granted in the same cycle when that bit is 0.
- R4: After a cycle with a grant, the state becomes the previous state shifted right by one, OR-ed with the collision vector.
- R5: After a cycle without a grant, the state becomes the previous state shifted right by one, with a 0 entering at the most significant bit.
- R6: A request refused because bit 0 is 1 is held inside the block. It is granted in the first later cycle in which bit 0 is 0, even after req_i has returned low.
- R7: Each accepted request, held or fresh, yields exactly one grant pulse one cycle long. No grant follows it unless a new request arrives.
- R8: After SLOTS-1 idle cycles the state is all zeros. The next request is then granted at once and reloads the collision vector, as after reset.
- R9: Two granted starts are never separated by a forbidden latency. With the default table and req_i held high, the grants repeat with latencies 1 then 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request to launch a new operation |
| grant_o | output | 1 | One-cycle pulse: start permitted in this cycle |
| state_o | output | SLOTS-1 | Current contents of the collision state register |

## Verification
Any wrong state bit shows on state_o in the next cycle. It also changes the timing of grant_o once it reaches bit 0, which takes at most SLOTS-1 cycles. A wrongly derived collision vector shows in the state value right after the first grant. A pending flag that is lost or stuck shows as a grant that is missing or extra within the few cycles after a blocked request. A greedy stream with the request held high checks the whole latency cycle against the 1, 7 grant pattern that the default table implies.

// File: rtl/pipe_cv_pkg.sv
package pipe_cv_pkg;

    // Largest reservation table supported: 16 stages by 16 slots.
    localparam int MAX_STAGES = 16;
    localparam int MAX_SLOTS  = 16;
    localparam int MAX_CELLS  = MAX_STAGES * MAX_SLOTS;

    typedef logic [MAX_CELLS-1:0] cells_t;

    // True when some row has two marked slots exactly lat apart.
    function automatic logic lat_forbidden(input cells_t tbl, input int stages,
                                           input int slots, input int lat);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < stages; s++) begin
            for (int i = 0; i + lat < slots; i++) begin
                if (tbl[s*slots + i] && tbl[s*slots + i + lat]) begin
                    hit = 1'b1;
                end
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/cv_derive.sv
module cv_derive #(
    parameter int                       STAGES    = 3,
    parameter int                       SLOTS     = 7,
    parameter logic [STAGES*SLOTS-1:0]  RES_TABLE = '0,
    localparam int                      W         = SLOTS - 1
) (
    output logic [W-1:0] cv_o
);
    localparam pipe_cv_pkg::cells_t CELLS = pipe_cv_pkg::cells_t'(RES_TABLE);

    // One constant bit per candidate latency 1..W.
    for (genvar k = 1; k <= W; k++) begin : g_lat
        localparam logic HIT = pipe_cv_pkg::lat_forbidden(CELLS, STAGES, SLOTS, k);
        assign cv_o[k-1] = HIT;
    end

endmodule

// File: rtl/cv_shift.sv
module cv_shift #(
    parameter  int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] cv_i,
    output logic [W-1:0] vec_o,
    output logic         exit_o
);
    typedef struct packed {
        logic [W-1:0] vec;
    } sreg_t;

    sreg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vec = {1'b0, st_q.vec[W-1:1]};
        if (load_i) begin
            st_d.vec = st_d.vec | cv_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_o  = st_q.vec;
    assign exit_o = st_q.vec[0];

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (vec_o == (($past(vec_o) >> 1) | $past(cv_i))));

    // R5
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (vec_o == ($past(vec_o) >> 1)));

endmodule

// File: rtl/req_hold.sv
module req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic allow_i,
    output logic grant_o
);
    typedef struct packed {
        logic pend;
    } hold_t;

    hold_t hd_d, hd_q;
    logic  want;

    always_comb begin
        want    = req_i | hd_q.pend;
        grant_o = want & allow_i;
        hd_d      = hd_q;
        hd_d.pend = want & ~allow_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !req_i) |=> !hd_q.pend);

endmodule

// File: rtl/pipe_init_ctrl.sv
module pipe_init_ctrl #(
    parameter int                      STAGES    = 3,
    parameter int                      SLOTS     = 7,
    parameter logic [STAGES*SLOTS-1:0] RES_TABLE = {7'b1000100, 7'b0001010, 7'b1000001},
    localparam int                     W         = SLOTS - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    output logic         grant_o,
    output logic [W-1:0] state_o
);
    logic [W-1:0] cv_w;
    logic [W-1:0] vec_w;
    logic         exit_w;
    logic         grant_w;

    cv_derive #(.STAGES(STAGES), .SLOTS(SLOTS), .RES_TABLE(RES_TABLE)) u_cv (
        .cv_o (cv_w)
    );

    cv_shift #(.W(W)) u_sreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (grant_w),
        .cv_i   (cv_w),
        .vec_o  (vec_w),
        .exit_o (exit_w)
    );

    req_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .allow_i (~exit_w),
        .grant_o (grant_w)
    );

    assign grant_o = grant_w;
    assign state_o = vec_w;

    // R3
    grant_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !state_o[0]);

    // Checker state: cycles since the last grant, saturating at SLOTS.
    localparam int CW = $clog2(SLOTS + 1);
    logic [CW-1:0] since_d, since_q;
    logic          forb_now;

    always_comb begin
        if (grant_w)                       since_d = CW'(1);
        else if (since_q == CW'(SLOTS))    since_d = since_q;
        else                               since_d = since_q + CW'(1);
        forb_now = 1'b0;
        for (int k = 1; k <= W; k++) begin
            if (since_q == CW'(k) && cv_w[k-1]) forb_now = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) since_q <= CW'(SLOTS);
        else        since_q <= since_d;
    end

    // R9
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !forb_now);

endmodule

// File: tb/sim_pipe_init_ctrl.sv
module sim_pipe_init_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       grant;
    logic [5:0] state;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pipe_init_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .grant_o (grant),
        .state_o (state)
    );

    // Drive req after the falling edge, then check this cycle's grant and state.
    task automatic step(input logic r, input logic eg, input logic [5:0] es, input string tag);
        @(negedge clk);
        req = r;
        #1;
        n_chk++;
        if (grant !== eg || state !== es) begin
            n_bad++;
            $display("FAIL %s: grant=%b state=%b, expected grant=%b state=%b",
                     tag, grant, state, eg, es);
        end
    endtask

    task automatic t_reset();
        step(1'b0, 1'b0, 6'b000000, "R2 reset state");
    endtask

    task automatic t_first();
        step(1'b1, 1'b1, 6'b000000, "R3 first request granted");
        step(1'b0, 1'b0, 6'b101010, "R1 R4 vector loaded");
        step(1'b0, 1'b0, 6'b010101, "R5 shift 1");
        step(1'b0, 1'b0, 6'b001010, "R5 shift 2");
        step(1'b0, 1'b0, 6'b000101, "R5 shift 3");
        step(1'b0, 1'b0, 6'b000010, "R5 shift 4");
        step(1'b0, 1'b0, 6'b000001, "R5 shift 5");
        step(1'b0, 1'b0, 6'b000000, "R8 idle to zero");
        step(1'b1, 1'b1, 6'b000000, "R8 restart granted");
        step(1'b0, 1'b0, 6'b101010, "R8 vector reloaded");
    endtask

    task automatic t_blocked();
        step(1'b1, 1'b0, 6'b010101, "R3 latency 2 blocked");
        step(1'b0, 1'b1, 6'b001010, "R6 held request granted");
        step(1'b0, 1'b0, 6'b101111, "R4 R7 merge, single pulse");
        step(1'b0, 1'b0, 6'b010111, "R5 drain");
        step(1'b0, 1'b0, 6'b001011, "R5 drain");
        step(1'b0, 1'b0, 6'b000101, "R5 drain");
        step(1'b0, 1'b0, 6'b000010, "R5 drain");
        step(1'b0, 1'b0, 6'b000001, "R7 no extra grant");
        step(1'b0, 1'b0, 6'b000000, "R8 zero");
    endtask

    task automatic t_greedy();
        step(1'b1, 1'b1, 6'b000000, "R9 greedy start");
        step(1'b1, 1'b1, 6'b101010, "R9 latency 1");
        step(1'b1, 1'b0, 6'b111111, "R9 wait");
        step(1'b1, 1'b0, 6'b011111, "R9 wait");
        step(1'b1, 1'b0, 6'b001111, "R9 wait");
        step(1'b1, 1'b0, 6'b000111, "R9 wait");
        step(1'b1, 1'b0, 6'b000011, "R9 wait");
        step(1'b1, 1'b0, 6'b000001, "R9 wait");
        step(1'b1, 1'b1, 6'b000000, "R9 latency 7");
        step(1'b1, 1'b1, 6'b101010, "R9 latency 1 again");
        step(1'b0, 1'b0, 6'b111111, "R9 R7 stop");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first();
        t_blocked();
        t_greedy();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule